// File: doc/BRIEF.md
# Mode-Dependent Memory Map Decoder

This block sits on the address bus of a small 8-bit controller. It captures two mode-strap pins at the moment reset is released and keeps that operating mode until the next reset. From the captured mode it derives four control bits: user ROM enable, bootstrap ROM enable, special mode and expanded bus. The bits are driven out so that the rest of the chip can see them.

On every cycle the 16-bit address is decoded into exactly one of six outputs:
- select for the register block,
- select for internal RAM,
- select for the bootstrap ROM,
- select for the user ROM,
- select for external memory,
- an "unmapped" flag.

A writable relocation register holds two page numbers. They place the RAM window and the register window on any 4 KB boundary. When windows overlap, a fixed priority picks the winner.

The memory arrays, the CPU and bus timing lie outside this block.

Top module: `memmap_decode`

## Requirements
- R1: While `rst_n` is low, the mode pins are sampled on every clock. The value sampled on the last low cycle is held after `rst_n` goes high. Pin changes after that have no effect on the control outputs until the next reset.
- R2: The captured mode `{mode_pin_b, mode_pin_a}` sets the control bits `{rom_on, boot_on, special_md, expanded_md}` as follows:
  - 2'b11 gives 0001 (expanded).
  - 2'b10 gives 1000 (single chip).
  - 2'b00 gives 1110 (bootstrap).
  - 2'b01 gives 0011 (test).
- R3: The relocation register `init_q` resets to 8'h01. Bits 7:4 are the RAM page and bits 3:0 are the register page. A cycle with `init_wr` high loads `init_wdata`, and the new value is visible after that clock edge.
- R4: The register window is the 128 bytes starting at `{init_q[3:0], 12'h000}`.
- R5: The RAM window is the 512 bytes starting at `{init_q[7:4], 12'h000}`.
- R6: The bootstrap ROM window is 16'hBF00 to 16'hBFFF. It decodes only when `boot_on` is 1.
- R7: The user ROM window is 16'hC000 to 16'hFFFF. It decodes only when `rom_on` is 1. Otherwise those addresses fall through to R10.
- R8: When windows overlap, the priority from highest to lowest is: register block, RAM, bootstrap ROM, user ROM.
- R9: Exactly one of `sel_regs`, `sel_ram`, `sel_boot`, `sel_urom`, `sel_ext` and `unmapped` is high at all times after reset.
- R10: An address that hits no internal window raises `sel_ext` when `expanded_md` is 1, and raises `unmapped` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is captured while low |
| mode_pin_b | input | 1 | Mode strap, upper bit |
| mode_pin_a | input | 1 | Mode strap, lower bit |
| addr | input | 16 | Bus address of the current access |
| init_wr | input | 1 | Write strobe for the relocation register |
| init_wdata | input | 8 | Data for the relocation register |
| init_q | output | 8 | Current relocation register value |
| rom_on | output | 1 | User ROM enabled |
| boot_on | output | 1 | Bootstrap ROM enabled |
| special_md | output | 1 | Special operating mode |
| expanded_md | output | 1 | External bus available |
| sel_regs | output | 1 | Register block selected |
| sel_ram | output | 1 | Internal RAM selected |
| sel_boot | output | 1 | Bootstrap ROM selected |
| sel_urom | output | 1 | User ROM selected |
| sel_ext | output | 1 | External memory selected |
| unmapped | output | 1 | No region claims the address |

## Verification
Two kinds of state can go wrong here: the latched mode and the relocation register.

A wrong latched mode shows on the four control outputs in the first cycle after reset release. It also moves whole decode regions. For example, the user ROM range turns into external or unmapped, and the bootstrap page appears or vanishes.

A wrong relocation value shows one clock after the write. The RAM or register window then moves to another page, and a sweep of all 65536 addresses sees selects appear where they should not.

Because the decode is combinational from these registers, every fault shows at the ports in the same cycle as the offending address.

// File: rtl/memmap_pkg.sv
// Shared types for the memory map decoder: operating mode encoding,
// the control bits that the mode implies, and internal region indices.
package memmap_pkg;

    // Strap value {pin_b, pin_a} captured at reset release.
    typedef enum logic [1:0] {
        MD_BOOT   = 2'b00,
        MD_TEST   = 2'b01,
        MD_SINGLE = 2'b10,
        MD_EXPAND = 2'b11
    } op_mode_e;

    // Control bits that follow from the captured mode.
    typedef struct packed {
        logic rom_on;
        logic boot_on;
        logic special;
        logic expanded;
    } mode_ctrl_t;

    // Index of each internal region; a lower index wins on overlap.
    localparam int RG_REGS = 0;
    localparam int RG_RAM  = 1;
    localparam int RG_BOOT = 2;
    localparam int RG_UROM = 3;
    localparam int RG_NUM  = 4;

    // Map a captured mode onto its control bits.
    function automatic mode_ctrl_t ctrl_of(op_mode_e m);
        mode_ctrl_t c;
        case (m)
            MD_EXPAND: c = '{rom_on: 1'b0, boot_on: 1'b0, special: 1'b0, expanded: 1'b1};
            MD_SINGLE: c = '{rom_on: 1'b1, boot_on: 1'b0, special: 1'b0, expanded: 1'b0};
            MD_BOOT:   c = '{rom_on: 1'b1, boot_on: 1'b1, special: 1'b1, expanded: 1'b0};
            default:   c = '{rom_on: 1'b0, boot_on: 1'b0, special: 1'b1, expanded: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mode_latch.sv
// Captures the mode straps while reset is held and keeps them afterwards.
// Assumes: the straps are stable for at least the last reset cycle.
module mode_latch
    import memmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_b,
    input  logic       pin_a,
    output mode_ctrl_t ctrl
);

    op_mode_e mode_q;

    // Track the straps during reset; hold the last sample once released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= op_mode_e'({pin_b, pin_a});
        end
    end

    // Derive the control bits from the held mode.
    always_comb begin
        ctrl = ctrl_of(mode_q);
    end

endmodule

// File: rtl/init_reg.sv
// Relocation register holding the RAM page (upper half) and the register
// page (lower half). Assumes: writes are single-cycle strobes.
module init_reg #(
    parameter int          W     = 8,
    parameter logic [W-1:0] RST_V = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Reset to the default page pair; load on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_V;
        end else if (wr) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/window_hit.sv
// Compares an address with a power-of-two aligned window.
// Assumes: the window of 2**SPAN_W bytes is aligned, so the low SPAN_W bits
// of base are ignored.
module window_hit #(
    parameter int ADDR_W = 16,
    parameter int SPAN_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              en,
    output logic              hit
);

    // Match the upper address bits against the window base.
    always_comb begin
        hit = en && (addr[ADDR_W-1:SPAN_W] == base[ADDR_W-1:SPAN_W]);
    end

endmodule

// File: rtl/sel_priority.sv
// Turns a vector of region hits into one-hot selects, with the lowest index
// winning. With no hit, the access goes to the external bus when allowed and
// is flagged unmapped otherwise. Assumes: N is at least 1.
module sel_priority #(
    parameter int N = 4
) (
    input  logic [N-1:0] hit,
    input  logic         ext_ok,
    output logic [N-1:0] sel,
    output logic         sel_ext,
    output logic         unmapped
);

    logic taken;

    // Fixed-priority scan from index 0 upward, then the fallback choice.
    always_comb begin
        sel   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (hit[i] && !taken) begin
                sel[i] = 1'b1;
                taken  = 1'b1;
            end
        end
        sel_ext  = !taken && ext_ok;
        unmapped = !taken && !ext_ok;
    end

endmodule

// File: rtl/memmap_decode.sv
// Mode-dependent memory map decoder.
// - The operating mode is captured from the straps at reset release.
// - The relocation register places RAM and register windows on page
//   boundaries.
// - Each address is decoded to exactly one select or the unmapped flag.
// Assumes: PAGE_W is wider than RAM_AW and REG_AW, and the fixed ROM windows
// are aligned to their size.
module memmap_decode
    import memmap_pkg::*;
#(
    parameter int                 ADDR_W    = 16,
    parameter int                 PAGE_W    = 12,
    parameter int                 RAM_AW    = 9,
    parameter int                 REG_AW    = 7,
    parameter int                 BOOT_AW   = 8,
    parameter int                 UROM_AW   = 14,
    parameter logic [ADDR_W-1:0]  BOOT_BASE = 16'hBF00,
    parameter logic [ADDR_W-1:0]  UROM_BASE = 16'hC000,
    parameter int                 PG_W      = ADDR_W - PAGE_W,
    parameter logic [2*PG_W-1:0]  INIT_RST  = 8'h01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_pin_b,
    input  logic                mode_pin_a,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                init_wr,
    input  logic [2*PG_W-1:0]   init_wdata,
    output logic [2*PG_W-1:0]   init_q,
    output logic                rom_on,
    output logic                boot_on,
    output logic                special_md,
    output logic                expanded_md,
    output logic                sel_regs,
    output logic                sel_ram,
    output logic                sel_boot,
    output logic                sel_urom,
    output logic                sel_ext,
    output logic                unmapped
);

    localparam int INIT_W = 2 * PG_W;

    mode_ctrl_t          ctrl;
    logic [ADDR_W-1:0]   base_v [RG_NUM];
    logic [RG_NUM-1:0]   en_v;
    logic [RG_NUM-1:0]   hit_v;
    logic [RG_NUM-1:0]   sel_v;

    mode_latch u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_b (mode_pin_b),
        .pin_a (mode_pin_a),
        .ctrl  (ctrl)
    );

    init_reg #(.W(INIT_W), .RST_V(INIT_RST)) u_init (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (init_wr),
        .wdata (init_wdata),
        .q     (init_q)
    );

    // Region bases and enables: relocatable pages for RAM and registers.
    always_comb begin
        base_v[RG_REGS] = {init_q[PG_W-1:0], {PAGE_W{1'b0}}};
        base_v[RG_RAM]  = {init_q[INIT_W-1:PG_W], {PAGE_W{1'b0}}};
        base_v[RG_BOOT] = BOOT_BASE;
        base_v[RG_UROM] = UROM_BASE;
        en_v[RG_REGS]   = 1'b1;
        en_v[RG_RAM]    = 1'b1;
        en_v[RG_BOOT]   = ctrl.boot_on;
        en_v[RG_UROM]   = ctrl.rom_on;
    end

    // One window comparator per internal region, sized by its index.
    for (genvar g = 0; g < RG_NUM; g++) begin : g_win
        localparam int SPAN = (g == RG_REGS) ? REG_AW :
                              (g == RG_RAM)  ? RAM_AW :
                              (g == RG_BOOT) ? BOOT_AW : UROM_AW;
        window_hit #(.ADDR_W(ADDR_W), .SPAN_W(SPAN)) u_hit (
            .addr (addr),
            .base (base_v[g]),
            .en   (en_v[g]),
            .hit  (hit_v[g])
        );
    end

    sel_priority #(.N(RG_NUM)) u_prio (
        .hit      (hit_v),
        .ext_ok   (ctrl.expanded),
        .sel      (sel_v),
        .sel_ext  (sel_ext),
        .unmapped (unmapped)
    );

    // Drive the named outputs from the internal vectors.
    always_comb begin
        rom_on      = ctrl.rom_on;
        boot_on     = ctrl.boot_on;
        special_md  = ctrl.special;
        expanded_md = ctrl.expanded;
        sel_regs    = sel_v[RG_REGS];
        sel_ram     = sel_v[RG_RAM];
        sel_boot    = sel_v[RG_BOOT];
        sel_urom    = sel_v[RG_UROM];
    end

endmodule

// File: rtl/memmap_decode_chk.sv
// Assertion checker for memmap_decode at its default parameters.
// It is bound to every instance of the top module.
module memmap_decode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        init_wr,
    input logic [7:0]  init_wdata,
    input logic [7:0]  init_q,
    input logic        rom_on,
    input logic        boot_on,
    input logic        special_md,
    input logic        expanded_md,
    input logic        sel_regs,
    input logic        sel_ram,
    input logic        sel_boot,
    input logic        sel_urom,
    input logic        sel_ext,
    input logic        unmapped
);

    assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable({rom_on, boot_on, special_md, expanded_md}));

    assert_expand_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (expanded_md && !special_md) |-> (!rom_on && !boot_on));

    assert_init_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (init_q == $past(init_wdata)));

    assert_regs_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_regs |-> (addr[15:12] == init_q[3:0] && addr[11:7] == 5'd0));

    assert_ram_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ram |-> (addr[15:12] == init_q[7:4] && addr[11:9] == 3'd0));

    assert_boot_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_boot |-> (boot_on && addr[15:8] == 8'hBF));

    assert_urom_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_urom |-> (rom_on && addr[15:14] == 2'b11));

    assert_regs_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:12] == init_q[3:0] && addr[11:7] == 5'd0) |-> sel_regs);

    assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_regs, sel_ram, sel_boot, sel_urom, sel_ext, unmapped}) == 1);

    assert_ext_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ext |-> expanded_md);

    assert_unmapped_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> !expanded_md);

endmodule

bind memmap_decode memmap_decode_chk u_chk (.*);

// File: tb/memmap_decode_bench.sv
// Bench for memmap_decode.
// - Resets into each of the four modes.
// - Checks the control bits and the relocation register.
// - Sweeps every address under three relocation settings against an
//   arithmetic model.
module memmap_decode_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_pin_b = 1'b0;
    logic        mode_pin_a = 1'b0;
    logic [15:0] addr = '0;
    logic        init_wr = 1'b0;
    logic [7:0]  init_wdata = '0;
    logic [7:0]  init_q;
    logic        rom_on, boot_on, special_md, expanded_md;
    logic        sel_regs, sel_ram, sel_boot, sel_urom, sel_ext, unmapped;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    memmap_decode u_memmap_decode (
        .clk(clk), .rst_n(rst_n), .mode_pin_b(mode_pin_b), .mode_pin_a(mode_pin_a),
        .addr(addr), .init_wr(init_wr), .init_wdata(init_wdata), .init_q(init_q),
        .rom_on(rom_on), .boot_on(boot_on), .special_md(special_md),
        .expanded_md(expanded_md), .sel_regs(sel_regs), .sel_ram(sel_ram),
        .sel_boot(sel_boot), .sel_urom(sel_urom), .sel_ext(sel_ext), .unmapped(unmapped)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    // Control bits {rom_on, boot_on, special, expanded} per mode (R2).
    function automatic logic [3:0] ctrl_exp(input logic [1:0] m);
        case (m)
            2'b11:   return 4'b0001;
            2'b10:   return 4'b1000;
            2'b00:   return 4'b1110;
            default: return 4'b0011;
        endcase
    endfunction

    // Expected {regs, ram, boot, urom, ext, unmapped} for one address.
    function automatic logic [5:0] sel_exp(input int a, input logic [7:0] iv, input logic [3:0] c);
        int pg  = a / 4096;
        int off = a % 4096;
        if (pg == int'(iv[3:0]) && off < 128)  return 6'b100000;
        if (pg == int'(iv[7:4]) && off < 512)  return 6'b010000;
        if (c[2] && a >= 'hBF00 && a <= 'hBFFF) return 6'b001000;
        if (c[3] && a >= 'hC000)               return 6'b000100;
        if (c[0])                              return 6'b000010;
        return 6'b000001;
    endfunction

    function automatic string tag_of(input logic [5:0] s);
        case (s)
            6'b100000: return "R4";
            6'b010000: return "R5";
            6'b001000: return "R6";
            6'b000100: return "R7";
            default:   return "R10";
        endcase
    endfunction

    // Reset into mode m, then move the straps to show they are ignored.
    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        {mode_pin_b, mode_pin_a} = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        {mode_pin_b, mode_pin_a} = ~m;
        repeat (2) @(negedge clk);
        check("R1_R2 ctrl", {28'd0, rom_on, boot_on, special_md, expanded_md}, {28'd0, ctrl_exp(m)});
        check("R3 init reset", {24'd0, init_q}, 32'h01);
    endtask

    task automatic write_init(input logic [7:0] v);
        @(negedge clk);
        init_wr = 1'b1;
        init_wdata = v;
        @(negedge clk);
        init_wr = 1'b0;
        check("R3 init write", {24'd0, init_q}, {24'd0, v});
    endtask

    task automatic sweep(input logic [1:0] m);
        logic [5:0] e;
        logic [5:0] got;
        for (int a = 0; a < 65536; a++) begin
            addr = a[15:0];
            #1;
            got = {sel_regs, sel_ram, sel_boot, sel_urom, sel_ext, unmapped};
            e = sel_exp(a, init_q, ctrl_exp(m));
            check(tag_of(e), {26'd0, got}, {26'd0, e});
        end
        addr = '0;
    endtask

    task automatic probe(input logic [15:0] a, input logic [5:0] e, input string req);
        addr = a;
        #1;
        check(req, {26'd0, sel_regs, sel_ram, sel_boot, sel_urom, sel_ext, unmapped}, {26'd0, e});
    endtask

    initial begin
        for (int mi = 0; mi < 4; mi++) begin
            logic [1:0] m = 2'(3 - mi);
            do_reset(m);
            sweep(m);
            write_init(8'h00);
            sweep(m);
            write_init(8'hBC);
            sweep(m);
            // R8: register window over RAM over user ROM on shared pages.
            if (m == 2'b00) begin
                write_init(8'hCC);
                probe(16'hC040, 6'b100000, "R8 regs over ram");
                probe(16'hC100, 6'b010000, "R8 ram over urom");
                probe(16'hC200, 6'b000100, "R8 urom fallback");
                write_init(8'hBB);
                probe(16'hBF10, 6'b001000, "R8 boot");
                probe(16'hB000, 6'b100000, "R8 regs over ram boot mode");
            end
            // R9: single-chip, unrelocated space gap is unmapped.
            if (m == 2'b10) probe(16'h8000, 6'b000001, "R9 R10 unmapped");
        end
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 195000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule